// File: doc/BRIEF.md
# Register-Driven Sobel Gradient Engine

This block computes Sobel edge gradients for one output pixel at a time under software control. A processor writes three vertically stacked 8-bit grayscale pixels into a data register, then writes a start code into a control register. The block pushes that column into a 3x3 window and convolves the window with the horizontal and vertical Sobel kernels. It then publishes both signed gradients and the sum of their squares.

Software sweeps an image by feeding one new column per start and reading the results once the ready flag is set. A byte-coded status value tells software whether a computation is still in flight. The square root of the combined value is left to software. The result is therefore the exact pre-root magnitude and is never rounded.

Top module: `sobel_regcore`

## Requirements
- R1: After a synchronous active-low reset, status reads 0x44, ready is 0, both gradients and the combined value are 0, and the 3x3 window holds all zeros.
- R2: A computation starts only when the least significant byte of the control register (word address 0) equals 0xAB. Any other byte value, including 0xAB placed in a higher byte, starts nothing and leaves the window unchanged.
- R3: When the start code is written on clock edge T, status reads 0x55 from edge T+1 through edge T+3. At edge T+4, ready rises and status returns to 0x44. Status never takes a value other than 0x55 or 0x44.
- R4: Each start shifts the window left by one column, dropping the oldest column. The new column enters on the right. Byte 0 of the pixel register (word address 1) is the top row, byte 1 the middle row and byte 2 the bottom row.
- R5: grad_x equals the window convolved with the horizontal kernel, rows top to bottom [-1 0 1; -2 0 2; -1 0 1], where column 0 is the oldest. It is a signed 12-bit value spanning -1020..+1020.
- R6: grad_y equals the window convolved with the vertical kernel, rows top to bottom [-1 -2 -1; 0 0 0; 1 2 1]. It is a signed 12-bit value.
- R7: mag_sq equals grad_x*grad_x + grad_y*grad_y as an unsigned 32-bit value, with no square root applied.
- R8: ready stays high, and the results stay unchanged, for as long as the control byte remains 0xAB. One write therefore produces exactly one computation. ready falls on the second edge after the control byte is written to another value.
- R9: Reads return the following values. Address 0 gives the control byte, zero-extended. Address 1 gives the 24-bit pixel column. Address 2 gives mag_sq. Address 3 gives grad_y sign-extended in bits 31:16 and grad_x sign-extended in bits 15:0. Address 4 gives ready in bit 8 and status in bits 7:0. Other addresses read 0.
- R10: Writes to addresses other than 0 and 1 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| grad_x | output | 12 | Signed horizontal gradient |
| grad_y | output | 12 | Signed vertical gradient |
| mag_sq | output | 32 | grad_x squared plus grad_y squared |
| status | output | 8 | 0x55 while computing, 0x44 otherwise |
| ready | output | 1 | Result valid, held while the start code remains |

## Verification
A wrong window column shows up on the first computation that uses it, as a mismatch of grad_x or grad_y at edge T+4. Because every stored column takes part in the next three results, a corrupted window is reported up to three starts later. A faulty state machine shows within one to four cycles of a write: status holds the wrong code, ready rises early or late, or a held start code runs a second computation that shifts the window and is caught on the following result.

// File: rtl/sobel_core_pkg.sv
// Package: shared constants, state type and kernel coefficient functions
// for the register-driven Sobel gradient engine.
// Assumes a fixed 3x3 window; the kernels are defined only for that size.
package sobel_core_pkg;

    localparam int WIN_ROWS = 3;
    localparam int WIN_COLS = 3;
    localparam int WIN_TAPS = WIN_ROWS * WIN_COLS;

    localparam logic [7:0] START_CODE  = 8'hAB;
    localparam logic [7:0] STAT_BUSY   = 8'h55;
    localparam logic [7:0] STAT_IDLE   = 8'h44;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_PIXEL  = 3'd1;
    localparam logic [2:0] ADDR_MAG    = 3'd2;
    localparam logic [2:0] ADDR_GRAD   = 3'd3;
    localparam logic [2:0] ADDR_STAT   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MUL  = 3'd1,
        ST_SUM  = 3'd2,
        ST_MAG  = 3'd3,
        ST_DONE = 3'd4
    } phase_t;

    // Horizontal kernel: sign from column, weight 2 on the middle row.
    function automatic int coef_h(input int row, input int col);
        return (col - 1) * ((row == 1) ? 2 : 1);
    endfunction

    // Vertical kernel: sign from row, weight 2 on the middle column.
    function automatic int coef_v(input int row, input int col);
        return (row - 1) * ((col == 1) ? 2 : 1);
    endfunction

endpackage

// File: rtl/sobel_regfile.sv
// Register decode: holds the control byte and the pixel column written by
// software and multiplexes all readable values onto the read bus.
// Assumes single-cycle write strobes and a combinational read path.
module sobel_regfile
    import sobel_core_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int PIX_W  = 8,
    parameter int GRAD_W = PIX_W + 4,
    parameter int MAG_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [7:0]               ctrl_byte,
    output logic [WIN_ROWS*PIX_W-1:0] column,
    input  logic signed [GRAD_W-1:0] gx,
    input  logic signed [GRAD_W-1:0] gy,
    input  logic [MAG_W-1:0]         mag,
    input  logic [7:0]               stat,
    input  logic                     rdy
);

    localparam int HALF  = DATA_W / 2;
    localparam int COL_W = WIN_ROWS * PIX_W;

    // Purpose: capture software writes to the control and pixel registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_byte <= '0;
            column    <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_CTRL))  ctrl_byte <= wdata[7:0];
            if (addr == ADDR_W'(ADDR_PIXEL)) column    <= wdata[COL_W-1:0];
        end
    end

    // Purpose: select the value returned for the current read address.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_CTRL):  rdata = DATA_W'(ctrl_byte);
            ADDR_W'(ADDR_PIXEL): rdata = DATA_W'(column);
            ADDR_W'(ADDR_MAG):   rdata = DATA_W'(mag);
            ADDR_W'(ADDR_GRAD):  rdata = {HALF'(gy), HALF'(gx)};
            ADDR_W'(ADDR_STAT):  rdata = DATA_W'({rdy, stat});
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/sobel_window.sv
// 3x3 pixel window built as one shift register per row. On each shift the
// oldest (left) column drops out and the new column enters on the right.
// Assumes byte r of the incoming column belongs to row r (row 0 on top).
module sobel_window
    import sobel_core_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [WIN_ROWS*PIX_W-1:0]     col_in,
    output logic [WIN_TAPS*PIX_W-1:0]     win
);

    for (genvar r = 0; r < WIN_ROWS; r++) begin : g_row
        logic [PIX_W-1:0] taps [WIN_COLS];

        // Purpose: shift this row left and load the new right-hand pixel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int c = 0; c < WIN_COLS; c++) taps[c] <= '0;
            end else if (shift_en) begin
                for (int c = 0; c < WIN_COLS - 1; c++) taps[c] <= taps[c+1];
                taps[WIN_COLS-1] <= col_in[r*PIX_W +: PIX_W];
            end
        end

        for (genvar c = 0; c < WIN_COLS; c++) begin : g_col
            assign win[(r*WIN_COLS + c)*PIX_W +: PIX_W] = taps[c];
        end
    end

endmodule

// File: rtl/sobel_conv.sv
// Three-stage arithmetic: all 18 pixel-times-coefficient products in one
// stage, the two gradient sums in the next, and the squared magnitude last.
// Assumes the controller raises each stage enable once per computation.
module sobel_conv
    import sobel_core_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int GRAD_W = PIX_W + 4,
    parameter int MAG_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIN_TAPS*PIX_W-1:0] win,
    input  logic                      mul_en,
    input  logic                      sum_en,
    input  logic                      mag_en,
    output logic signed [GRAD_W-1:0]  gx,
    output logic signed [GRAD_W-1:0]  gy,
    output logic [MAG_W-1:0]          mag
);

    localparam int PROD_W = PIX_W + 3;

    logic signed [PROD_W-1:0] pix_ext [WIN_TAPS];
    logic signed [PROD_W-1:0] prod_h  [WIN_TAPS];
    logic signed [PROD_W-1:0] prod_v  [WIN_TAPS];
    logic signed [GRAD_W-1:0] sum_h, sum_v;
    logic signed [MAG_W-1:0]  gx_w, gy_w, sq_sum;

    // Purpose: zero-extend each window pixel into a signed operand.
    always_comb begin
        for (int i = 0; i < WIN_TAPS; i++)
            pix_ext[i] = signed'({{(PROD_W-PIX_W){1'b0}}, win[i*PIX_W +: PIX_W]});
    end

    // Purpose: form every product for both kernels in a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_TAPS; i++) begin
                prod_h[i] <= '0;
                prod_v[i] <= '0;
            end
        end else if (mul_en) begin
            for (int i = 0; i < WIN_TAPS; i++) begin
                prod_h[i] <= pix_ext[i] * PROD_W'(coef_h(i / WIN_COLS, i % WIN_COLS));
                prod_v[i] <= pix_ext[i] * PROD_W'(coef_v(i / WIN_COLS, i % WIN_COLS));
            end
        end
    end

    // Purpose: add the registered products into the two gradients.
    always_comb begin
        sum_h = '0;
        sum_v = '0;
        for (int i = 0; i < WIN_TAPS; i++) begin
            sum_h = sum_h + GRAD_W'(prod_h[i]);
            sum_v = sum_v + GRAD_W'(prod_v[i]);
        end
    end

    // Purpose: register the gradient sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gx <= '0;
            gy <= '0;
        end else if (sum_en) begin
            gx <= sum_h;
            gy <= sum_v;
        end
    end

    assign gx_w   = MAG_W'(gx);
    assign gy_w   = MAG_W'(gy);
    assign sq_sum = gx_w * gx_w + gy_w * gy_w;

    // Purpose: register the pre-root magnitude.
    always_ff @(posedge clk) begin
        if (!rst_n)      mag <= '0;
        else if (mag_en) mag <= unsigned'(sq_sum);
    end

endmodule

// File: rtl/sobel_ctrl.sv
// Start and status sequencer. Waits for the start code, walks the shift,
// multiply, sum and magnitude stages, then holds ready until software
// removes the start code so that one write yields one computation.
// Assumes the control byte is stable while it is compared.
module sobel_ctrl
    import sobel_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ctrl_byte,
    output logic       shift_en,
    output logic       mul_en,
    output logic       sum_en,
    output logic       mag_en,
    output logic [7:0] stat,
    output logic       rdy
);

    phase_t phase, phase_nx;
    logic   start_seen;

    assign start_seen = (ctrl_byte == START_CODE);

    // Purpose: choose the next phase.
    always_comb begin
        phase_nx = phase;
        case (phase)
            ST_IDLE: if (start_seen)  phase_nx = ST_MUL;
            ST_MUL:                   phase_nx = ST_SUM;
            ST_SUM:                   phase_nx = ST_MAG;
            ST_MAG:                   phase_nx = ST_DONE;
            ST_DONE: if (!start_seen) phase_nx = ST_IDLE;
            default:                  phase_nx = ST_IDLE;
        endcase
    end

    // Purpose: advance the phase register and the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
            rdy   <= 1'b0;
        end else begin
            phase <= phase_nx;
            if (phase == ST_MAG)                     rdy <= 1'b1;
            else if (phase == ST_DONE && !start_seen) rdy <= 1'b0;
        end
    end

    assign shift_en = (phase == ST_IDLE) && start_seen;
    assign mul_en   = (phase == ST_MUL);
    assign sum_en   = (phase == ST_SUM);
    assign mag_en   = (phase == ST_MAG);
    assign stat     = (phase == ST_MUL || phase == ST_SUM || phase == ST_MAG)
                      ? STAT_BUSY : STAT_IDLE;

endmodule

// File: rtl/sobel_regcore.sv
// Top level of the register-driven Sobel gradient engine: register decode,
// window, arithmetic pipeline and sequencer.
// Assumes one software write per cycle at most and a square root in software.
module sobel_regcore
    import sobel_core_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int PIX_W  = 8,
    parameter int GRAD_W = PIX_W + 4,
    parameter int MAG_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic signed [GRAD_W-1:0] grad_x,
    output logic signed [GRAD_W-1:0] grad_y,
    output logic [MAG_W-1:0]         mag_sq,
    output logic [7:0]               status,
    output logic                     ready
);

    logic [7:0]                ctrl_byte;
    logic [WIN_ROWS*PIX_W-1:0] column;
    logic [WIN_TAPS*PIX_W-1:0] window;
    logic                      shift_en, mul_en, sum_en, mag_en;

    sobel_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W),
        .GRAD_W(GRAD_W), .MAG_W(MAG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_byte(ctrl_byte),
        .column(column), .gx(grad_x), .gy(grad_y), .mag(mag_sq),
        .stat(status), .rdy(ready)
    );

    sobel_window #(.PIX_W(PIX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .col_in(column), .win(window)
    );

    sobel_conv #(.PIX_W(PIX_W), .GRAD_W(GRAD_W), .MAG_W(MAG_W)) u_conv (
        .clk(clk), .rst_n(rst_n), .win(window), .mul_en(mul_en),
        .sum_en(sum_en), .mag_en(mag_en), .gx(grad_x), .gy(grad_y),
        .mag(mag_sq)
    );

    sobel_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte),
        .shift_en(shift_en), .mul_en(mul_en), .sum_en(sum_en),
        .mag_en(mag_en), .stat(status), .rdy(ready)
    );

endmodule

// File: rtl/sobel_regcore_chk.sv
// Checker for the Sobel gradient engine, attached to every instance by bind.
module sobel_regcore_chk #(
    parameter int GRAD_W = 12,
    parameter int MAG_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [7:0]               ctrl_byte,
    input logic [7:0]               status,
    input logic                     ready,
    input logic signed [GRAD_W-1:0] grad_x,
    input logic signed [GRAD_W-1:0] grad_y,
    input logic [MAG_W-1:0]         mag_sq
);

    logic signed [MAG_W-1:0] gxe, gye;
    assign gxe = MAG_W'(grad_x);
    assign gye = MAG_W'(grad_y);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status == 8'h44 && !ready && mag_sq == '0));

    a_r3_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h55 || status == 8'h44));

    a_r3_busy_excludes_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h55) |-> !ready);

    a_r3_ready_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(status) == 8'h55));

    a_r8_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ctrl_byte == 8'hAB) |=> (ready && $stable(grad_x) && $stable(mag_sq)));

    a_r7_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mag_sq == MAG_W'(gxe * gxe + gye * gye)));

endmodule

bind sobel_regcore sobel_regcore_chk #(.GRAD_W(GRAD_W), .MAG_W(MAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .status(status),
    .ready(ready), .grad_x(grad_x), .grad_y(grad_y), .mag_sq(mag_sq)
);

// File: tb/tb_sobel_regcore.sv
module tb_sobel_regcore;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic signed [11:0] grad_x, grad_y;
    logic [31:0] mag_sq;
    logic [7:0]  status;
    logic        ready;

    int n_checks = 0;
    int n_fail = 0;
    int bw [3][3];
    int KH [3][3] = '{'{-1, 0, 1}, '{-2, 0, 2}, '{-1, 0, 1}};
    int KV [3][3] = '{'{-1, -2, -1}, '{0, 0, 0}, '{1, 2, 1}};
    int exp_gx, exp_gy;

    always #5 clk = ~clk;

    sobel_regcore dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grad_x(grad_x),
        .grad_y(grad_y), .mag_sq(mag_sq), .status(status), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic model_push(input logic [23:0] col);
        for (int r = 0; r < 3; r++) begin
            bw[r][0] = bw[r][1];
            bw[r][1] = bw[r][2];
            bw[r][2] = int'(col[r*8 +: 8]);
        end
        exp_gx = 0; exp_gy = 0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                exp_gx += bw[r][c] * KH[r][c];
                exp_gy += bw[r][c] * KV[r][c];
            end
    endtask

    // One column: write pixels, start, check timing (R3), results (R4..R7), release (R8).
    task automatic run_col(input logic [23:0] col);
        longint em;
        wr(3'd1, {8'h00, col});
        wr(3'd0, 32'h0000_00AB);
        model_push(col);
        em = longint'(exp_gx) * exp_gx + longint'(exp_gy) * exp_gy;
        @(negedge clk);
        chk(status == 8'h55, "R3 busy after start", status, 8'h55);
        @(negedge clk); @(negedge clk);
        chk(!ready && status == 8'h55, "R3 still busy at T+3", ready, 0);
        @(negedge clk);
        chk(ready == 1'b1, "R3 ready at T+4", ready, 1);
        chk(status == 8'h44, "R3 idle code at T+4", status, 8'h44);
        chk(int'(grad_x) == exp_gx, "R4 R5 grad_x", grad_x, exp_gx);
        chk(int'(grad_y) == exp_gy, "R4 R6 grad_y", grad_y, exp_gy);
        chk(longint'(mag_sq) == em, "R7 mag_sq", mag_sq, em);
        wr(3'd0, 32'h0);
        chk(ready == 1'b1, "R8 ready one edge after release", ready, 1);
        @(negedge clk);
        chk(ready == 1'b0, "R8 ready cleared", ready, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(status == 8'h44, "R1 status", status, 8'h44);
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(grad_x == 0 && grad_y == 0, "R1 gradients", grad_x, 0);
        chk(mag_sq == 0, "R1 mag", mag_sq, 0);
        rd(3'd1, d);
        chk(d == 0, "R1 pixel reg", d, 0);
        run_col(24'h0);
        chk(mag_sq == 0, "R1 window zero", mag_sq, 0);
    endtask

    task automatic t_ramp();
        run_col(24'h1E140A);
        run_col(24'h3C3228);
        run_col(24'h5A5046);
        run_col(24'h0F0505);
    endtask

    task automatic t_extremes();
        run_col(24'h000000); run_col(24'h000000); run_col(24'hFFFFFF);
        chk(int'(grad_x) == 1020, "R5 max +gx", grad_x, 1020);
        run_col(24'h000000); run_col(24'h000000);
        chk(int'(grad_x) == -1020, "R5 max -gx", grad_x, -1020);
        run_col(24'hFF0000); run_col(24'hFF0000); run_col(24'hFF0000);
        chk(int'(grad_y) == 1020, "R6 max +gy", grad_y, 1020);
        run_col(24'h0000FF); run_col(24'hFF00FF);
    endtask

    task automatic t_no_start();
        logic [31:0] d;
        logic [11:0] gx0;
        gx0 = grad_x;
        wr(3'd1, 32'h00_123456);
        wr(3'd0, 32'h0000_00AA);
        repeat (6) @(negedge clk);
        chk(status == 8'h44 && !ready, "R2 0xAA does not start", status, 8'h44);
        wr(3'd0, 32'h0000_AB00);
        repeat (6) @(negedge clk);
        chk(status == 8'h44 && !ready, "R2 high byte 0xAB ignored", status, 8'h44);
        chk(grad_x == gx0, "R2 outputs untouched", grad_x, gx0);
        rd(3'd0, d);
        chk(d == 32'h0, "R2 ctrl byte readback", d, 0);
        wr(3'd0, 32'h0);
        run_col(24'h808080);
    endtask

    task automatic t_hold();
        logic [31:0] m0;
        wr(3'd1, 32'h00_102030);
        wr(3'd0, 32'h0000_00AB);
        model_push(24'h102030);
        repeat (4) @(negedge clk);
        m0 = mag_sq;
        repeat (8) @(negedge clk);
        chk(ready == 1'b1 && status == 8'h44, "R8 ready held", ready, 1);
        chk(mag_sq == m0, "R8 result stable", mag_sq, m0);
        wr(3'd0, 32'h0);
        @(negedge clk);
        run_col(24'h010203);
    endtask

    task automatic t_regmap();
        logic [31:0] d, m0;
        wr(3'd1, {8'h00, 24'hFF0000}); wr(3'd0, 32'h0000_00AB);
        model_push(24'hFF0000);
        repeat (4) @(negedge clk);
        rd(3'd2, d);
        chk(d == mag_sq, "R9 mag readback", d, mag_sq);
        rd(3'd3, d);
        chk(d == {{4{grad_y[11]}}, grad_y, {4{grad_x[11]}}, grad_x}, "R9 grad readback", d, 0);
        chk(int'($signed(d[15:0])) == exp_gx, "R9 grad_x field", $signed(d[15:0]), exp_gx);
        rd(3'd4, d);
        chk(d == 32'h0000_0144, "R9 status readback", d, 32'h144);
        rd(3'd1, d);
        chk(d == 32'h00FF_0000, "R9 pixel readback", d, 32'h00FF0000);
        rd(3'd0, d);
        chk(d == 32'h0000_00AB, "R9 ctrl readback", d, 32'hAB);
        rd(3'd6, d);
        chk(d == 0, "R9 unmapped reads zero", d, 0);
        m0 = mag_sq;
        wr(3'd2, 32'hDEAD_BEEF); wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'h1234);
        rd(3'd2, d);
        chk(d == m0, "R10 mag not writable", d, m0);
        chk(ready && status == 8'h44, "R10 status not writable", status, 8'h44);
        wr(3'd0, 32'h0);
        @(negedge clk);
        run_col(24'h00FF00);
    endtask

    initial begin
        for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) bw[r][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_extremes();
        t_no_start();
        t_hold();
        t_regmap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule